// File: doc/BRIEF.md
# I2C Bus Event Status and Interrupt Block

This block watches the already synchronized and filtered SCL and SDA lines of an I2C bus and turns bus activity into five status flags and one interrupt request. It counts SCL rising edges inside each byte and reports byte completion. Byte completion falls on the ninth edge when the local side transmits, because the returned ACK/NAK belongs to the byte. It falls on the eighth edge when the local side receives. It also reports that an address byte has arrived, and it captures the acknowledge bit returned after a transmitted byte. It detects start and stop conditions by itself. It flags a stop, and it flags a bus error when a start or stop cuts into the middle of a byte.

The surrounding controller drives the transfer direction and an address-phase flag, and pulses a clear strobe once it has serviced the flags. Every flag is produced at a fixed cycle distance from the filtered bus edge that causes it. Firmware and neighbouring logic can therefore rely on exact latencies. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `i2c_bus_event_status`

## Requirements
- R1: With `dir_tx`=1, status bit 0 (byte done) is 0 after the eighth SCL rising edge of a byte. It reads 1 one cycle after the first clock sample that sees `scl_f` high on the ninth rising edge.
- R2: With `dir_tx`=0, status bit 0 reads 1 one cycle after the first sample of the eighth SCL rising edge, and is 0 after the seventh.
- R3: Status bit 1 (address byte) is set in the same cycle as bit 0 only when `addr_phase`=1 at that edge, and never otherwise.
- R4: Status bit 2 (last received bit) takes the `scl_f`-rise sample of `sda_f` on the ninth rising edge when `dir_tx`=1, with 1 meaning NAK. A ninth edge with `dir_tx`=0 leaves it unchanged.
- R5: Status bit 3 (stop) reads 0 one cycle after, and 1 two cycles after, the first sample in which `sda_f` has risen while `scl_f` was high in both that sample and the one before.
- R6: Status bit 4 (bus error) is set two cycles after a start (`sda_f` falling while `scl_f` is high) or a stop, when 2 to 8 SCL rising edges have been counted in the current byte. It is not set for a stop after the first edge of a byte or after the ninth edge.
- R7: A start, or a stop, restarts the edge count at zero, so the next byte-done point is counted from that condition. After the ninth edge, the next rising edge counts as edge one.
- R8: Status bits stay set until `clr` is sampled high, which clears all five bits on the next cycle. A flag being set in the same cycle as `clr` is kept.
- R9: `irq` equals the OR of `status & irq_en` in the same cycle, with `irq_en` bits in the same positions as the status bits.
- R10: After reset, `status` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| scl_f | input | 1 | Synchronized, filtered SCL |
| sda_f | input | 1 | Synchronized, filtered SDA |
| dir_tx | input | 1 | 1 = local side transmits the current byte |
| addr_phase | input | 1 | 1 = current byte carries the slave address |
| clr | input | 1 | Clear strobe for all status bits |
| irq_en | input | 5 | Per-bit interrupt enable |
| status | output | 5 | {bus error, stop, last bit, address, byte done} |
| irq | output | 1 | Interrupt request |

## Verification
A new byte-done event and the clear strobe can fall in the same cycle. The bench first leaves stop and bus-error flags set from earlier scenarios. It then raises `clr` in exactly the cycle whose clock edge also samples the ninth SCL rise of a transmitted byte. The status must then read only the byte-done bit, with every older flag gone. A second overlap joins stop and bus error: a stop that ends a half-sent byte must raise both flags on the same cycle.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int ST_W    = 5;
  localparam int ST_BYTE = 0;
  localparam int ST_ADDR = 1;
  localparam int ST_LRB  = 2;
  localparam int ST_STOP = 3;
  localparam int ST_BERR = 4;
  typedef logic [ST_W-1:0] st_vec_t;
endpackage

// File: rtl/i2c_line_edges.sv
module i2c_line_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_q     <= scl_f;
      sda_q     <= sda_f;
      start_det <= scl_f & scl_q & sda_q & ~sda_f;
      stop_det  <= scl_f & scl_q & ~sda_q & sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
endmodule

// File: rtl/i2c_bit_counter.sv
module i2c_bit_counter #(
  parameter int DATA_BITS = 8,
  parameter int CW        = $clog2(DATA_BITS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          restart,
  input  logic          dir_tx,
  output logic [CW-1:0] cnt,
  output logic          byte_evt,
  output logic          ack_evt,
  output logic          mid_byte
);
  localparam logic [CW-1:0] TX_AT  = CW'(DATA_BITS);
  localparam logic [CW-1:0] RX_AT  = CW'(DATA_BITS - 1);
  localparam logic [CW-1:0] WRAP   = CW'(DATA_BITS + 1);
  localparam logic [CW-1:0] ONE    = CW'(1);
  localparam logic [CW-1:0] MID_LO = CW'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (scl_rise)       cnt <= (cnt == WRAP) ? ONE : cnt + ONE;
  end

  // cnt holds the number of edges before this one, so edge number is cnt+1
  assign byte_evt = scl_rise & (dir_tx ? (cnt == TX_AT) : (cnt == RX_AT));
  assign ack_evt  = scl_rise & dir_tx & (cnt == TX_AT);
  assign mid_byte = (cnt >= MID_LO) && (cnt <= TX_AT);
endmodule

// File: rtl/i2c_status_regs.sv
module i2c_status_regs
  import i2c_evt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  st_vec_t set,
  input  logic    lrb_val,
  input  st_vec_t irq_en,
  output st_vec_t status,
  output logic    irq
);
  for (genvar i = 0; i < ST_W; i++) begin : g_bit
    if (i == ST_LRB) begin : g_value
      // value bit: loaded on the acknowledge edge, otherwise cleared by clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      status[i] <= 1'b0;
        else if (set[i]) status[i] <= lrb_val;
        else if (clr)    status[i] <= 1'b0;
      end
    end else begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      status[i] <= 1'b0;
        else if (set[i]) status[i] <= 1'b1;
        else if (clr)    status[i] <= 1'b0;
      end
    end
  end

  assign irq = |(status & irq_en);
endmodule

// File: rtl/i2c_bus_event_status.sv
module i2c_bus_event_status
  import i2c_evt_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_f,
  input  logic            sda_f,
  input  logic            dir_tx,
  input  logic            addr_phase,
  input  logic            clr,
  input  logic [ST_W-1:0] irq_en,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  localparam int CW = $clog2(DATA_BITS + 2);

  logic          scl_rise, start_det, stop_det;
  logic [CW-1:0] bit_cnt;
  logic          byte_evt, ack_evt, mid_byte;
  st_vec_t       set;

  i2c_line_edges u_edges (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .scl_rise  (scl_rise),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_bit_counter #(.DATA_BITS(DATA_BITS), .CW(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .restart  (start_det | stop_det),
    .dir_tx   (dir_tx),
    .cnt      (bit_cnt),
    .byte_evt (byte_evt),
    .ack_evt  (ack_evt),
    .mid_byte (mid_byte)
  );

  always_comb begin
    set          = '0;
    set[ST_BYTE] = byte_evt;
    set[ST_ADDR] = byte_evt & addr_phase;
    set[ST_LRB]  = ack_evt;
    set[ST_STOP] = stop_det;
    set[ST_BERR] = (start_det | stop_det) & mid_byte;
  end

  i2c_status_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .set     (set),
    .lrb_val (sda_f),
    .irq_en  (irq_en),
    .status  (status),
    .irq     (irq)
  );
endmodule

// File: rtl/i2c_event_checker.sv
module i2c_event_checker
  import i2c_evt_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int CW        = $clog2(DATA_BITS + 2)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_f,
  input logic            sda_f,
  input logic            dir_tx,
  input logic            clr,
  input logic            scl_rise,
  input logic            start_det,
  input logic [CW-1:0]   bit_cnt,
  input logic [ST_W-1:0] status
);
  localparam logic [CW-1:0] TX_AT = CW'(DATA_BITS);
  localparam logic [CW-1:0] RX_AT = CW'(DATA_BITS - 1);
  localparam logic [CW-1:0] LO    = CW'(2);

  p_tx_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && dir_tx && bit_cnt == TX_AT) |=> status[ST_BYTE]);

  p_rx_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && !dir_tx && bit_cnt == RX_AT) |=> status[ST_BYTE]);

  p_addr_with_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_ADDR]) |-> status[ST_BYTE]);

  p_lrb_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && dir_tx && bit_cnt == TX_AT) |=> status[ST_LRB] == $past(sda_f));

  p_stop_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f) && sda_f && !$past(sda_f)) |=> ##1 status[ST_STOP]);

  p_start_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && bit_cnt >= LO && bit_cnt <= TX_AT) |=> status[ST_BERR]);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && status[ST_BYTE]) |=> status[ST_BYTE]);
endmodule

bind i2c_bus_event_status i2c_event_checker #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_f     (scl_f),
  .sda_f     (sda_f),
  .dir_tx    (dir_tx),
  .clr       (clr),
  .scl_rise  (scl_rise),
  .start_det (start_det),
  .bit_cnt   (bit_cnt),
  .status    (status)
);

// File: tb/i2c_bus_event_status_tb_top.sv
`timescale 1ns/1ps
module i2c_bus_event_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_f = 1'b1, sda_f = 1'b1;
  logic       dir_tx = 1'b1, addr_phase = 1'b0, clr = 1'b0;
  logic [4:0] irq_en = 5'h1F;
  logic [4:0] status;
  logic       irq;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  i2c_bus_event_status dut_i (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .dir_tx(dir_tx), .addr_phase(addr_phase), .clr(clr),
    .irq_en(irq_en), .status(status), .irq(irq)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one SCL bit; returns on the first negedge after the rise was sampled
  task automatic clk_bit(input logic v, input logic with_clr);
    @(negedge clk) scl_f = 1'b0;
    @(negedge clk) sda_f = v;
    @(negedge clk) begin scl_f = 1'b1; clr = with_clr; end
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic bits(input int n, input logic v);
    for (int i = 0; i < n; i++) clk_bit(v, 1'b0);
  endtask

  // requires scl_f and sda_f both high
  task automatic send_start();
    @(negedge clk) sda_f = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // returns right after SDA has been driven high
  task automatic send_stop();
    @(negedge clk) scl_f = 1'b0;
    @(negedge clk) sda_f = 1'b0;
    @(negedge clk) scl_f = 1'b1;
    @(negedge clk) sda_f = 1'b1;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 status after reset", status, 5'b00000);
    check("R10 irq after reset", {4'b0, irq}, 5'b00000);
  endtask

  task automatic t_tx_byte();
    dir_tx = 1'b1; addr_phase = 1'b0; irq_en = 5'h1F;
    send_start();
    bits(7, 1'b0);
    clk_bit(1'b1, 1'b0);
    check("R1 no byte done after 8th edge in tx", status, 5'b00000);
    clk_bit(1'b1, 1'b0);
    check("R1/R3/R4 tx 9th edge: byte done, NAK, no address", status, 5'b00101);
    check("R9 irq with all enabled", {4'b0, irq}, 5'b00001);
    send_stop();
    @(negedge clk);
    check("R5 stop not yet one cycle after", {4'b0, status[3]}, 5'b00000);
    @(negedge clk);
    check("R5/R6 stop after two cycles, no bus error at edge one", status, 5'b01101);
    pulse_clr();
    check("R8 clr empties status", status, 5'b00000);
    check("R9 irq drops after clear", {4'b0, irq}, 5'b00000);
  endtask

  task automatic t_rx_addr();
    dir_tx = 1'b0; addr_phase = 1'b1;
    send_start();
    bits(7, 1'b0);
    check("R2 no byte done after 7th edge in rx", status, 5'b00000);
    clk_bit(1'b1, 1'b0);
    check("R2/R3 rx 8th edge: byte done with address", status, 5'b00011);
    clk_bit(1'b1, 1'b0);
    check("R4/R8 rx 9th edge leaves last-bit alone, flags held", status, 5'b00011);
    addr_phase = 1'b0;
    send_stop();
    @(negedge clk); @(negedge clk);
    pulse_clr();
    check("R8 clr after rx byte", status, 5'b00000);
  endtask

  task automatic t_restart_mid();
    dir_tx = 1'b1;
    send_start();
    bits(4, 1'b1);
    send_start_no_wait();
    @(negedge clk);
    check("R6 bus error not yet one cycle after start", {4'b0, status[4]}, 5'b00000);
    @(negedge clk);
    check("R6 start at edge 4 gives bus error", {4'b0, status[4]}, 5'b00001);
    bits(5, 1'b0);
    check("R7 count restarted: no byte done 5 edges after restart", {4'b0, status[0]}, 5'b00000);
    bits(4, 1'b0);
    check("R7 byte done on 9th edge after restart", {4'b0, status[0]}, 5'b00001);
    send_stop();
    @(negedge clk); @(negedge clk);
    check("R8 flags accumulate: byte, stop, bus error", status, 5'b11001);
  endtask

  task automatic send_start_no_wait();
    @(negedge clk) sda_f = 1'b0;
  endtask

  task automatic t_mask();
    irq_en = 5'b00100;
    @(negedge clk);
    check("R9 irq low when only a clear bit is enabled", {4'b0, irq}, 5'b00000);
    irq_en = 5'b10000;
    @(negedge clk);
    check("R9 irq high when bus error is enabled", {4'b0, irq}, 5'b00001);
    irq_en = 5'h1F;
  endtask

  task automatic t_collide();
    dir_tx = 1'b1;
    send_start();
    bits(8, 1'b0);
    clk_bit(1'b0, 1'b1);
    check("R8 clr in the byte-done cycle keeps only the new flag", status, 5'b00001);
    send_stop();
    @(negedge clk); @(negedge clk);
    pulse_clr();
  endtask

  task automatic t_stop_mid();
    send_start();
    bits(3, 1'b1);
    send_stop();
    @(negedge clk);
    check("R6 no flag one cycle after mid-byte stop", status, 5'b00000);
    @(negedge clk);
    check("R5/R6 mid-byte stop gives stop and bus error together", status, 5'b11000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_byte();
    t_rx_addr();
    t_restart_mid();
    t_mask();
    t_collide();
    t_stop_mid();
    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule